// File: doc/BRIEF.md
# DMA Completion Interrupt Mask and Status Unit

This block gathers completion events from a DMA engine and presents them to software through a small register window. A one-cycle pulse on a channel's transmit-done or receive-done input sets that channel's bit in the raw status of its group. A host-error pulse sets bit 1 of a separate DMA-level group. Each group has its own enable mask. Software can change the mask only by writing ones to a set register or to a clear register. A read-only masked view returns raw status ANDed with the mask, and one interrupt line is the OR of every masked bit in all three groups.

Software acknowledges an interrupt by writing a vector value to an end-of-interrupt register. That write clears the raw status of every group. An error status register holds a transmit error code and channel and a receive error code and channel. The hardware loads these fields on a capture strobe and software may overwrite them. The register also shows a live idle flag.

Register access is a single 32-bit port. A write happens in the cycle that `reg_wr` is high, and read data is combinational on `reg_addr`. Unmapped offsets read as zero.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset every raw status bit, every mask bit, the end-of-interrupt value and every error field are zero, and `irq` is low.
- R2: A pulse on `tx_done[i]` or `rx_done[i]` sets bit i of raw status at 0x80 or 0xA0. A pulse on `host_err` sets bit 1 of raw status at 0xB0. The bit reads back as set from the cycle after the pulse's clock edge.
- R3: Writing to mask-set (0x88 transmit, 0xA8 receive, 0xB8 DMA-level) enables each source whose data bit is 1. Zero data bits leave the mask unchanged.
- R4: Writing to mask-clear (0x8C, 0xAC, 0xBC) disables each source whose data bit is 1. Writing all ones disables the whole group.
- R5: Masked status (0x84, 0xA4, 0xB4) reads raw status AND mask of its group.
- R6: `irq` is high exactly when any masked status bit of any group is 1.
- R7: A write to 0x94 clears raw status in all three groups, and 0x94 reads back the last value written.
- R8: When an event pulse and an end-of-interrupt write fall on the same clock edge, the event's bit is set afterwards.
- R9: Reading a mask-set or a mask-clear offset returns the current mask of that group.
- R10: Writes to the raw and masked status offsets have no effect on any register.
- R11: Error status at 0x24 has idle at bit 31, transmit error code at 23:20, transmit error channel at 18:16, receive error code at 15:12 and receive error channel at 10:8. `err_capture` loads the four fields from the inputs, and a software write loads them from the same bit positions. Bit 31 always shows `dma_idle` and cannot be written. All other bits read 0.
- R12: When `err_capture` and a software write to 0x24 occur in the same cycle, the captured input values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_done | input | NCH | Transmit completion pulses, one per channel |
| rx_done | input | NCH | Receive completion pulses, one per channel |
| host_err | input | 1 | Host error pulse |
| err_capture | input | 1 | Load error fields from the inputs |
| err_tx_code | input | 4 | Transmit error code |
| err_tx_chan | input | 3 | Transmit error channel |
| err_rx_code | input | 4 | Receive error code |
| err_rx_chan | input | 3 | Receive error channel |
| dma_idle | input | 1 | Engine idle flag |
| irq | output | 1 | Combined interrupt |

## Verification
A table of event and mask patterns is applied. It covers a lone low channel, a top channel hidden by its mask, a receive pattern partly masked, a host error against only the unused DMA-level bit 0, a host error enabled, and every source together. These show whether each group's bit positions are right and whether one group's mask leaks into another. Directed cases then cover an event on the same edge as an acknowledge, stray writes to status offsets, zero bits in set data, and mask readback through both the set and the clear offsets. Further directed cases cover a capture that collides with a software write and an attempt to write the idle flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ECODE_W = 4;
  localparam int ECHAN_W = 3;
  localparam int ERR_W = 2 * (ECODE_W + ECHAN_W);

  localparam logic [ADDR_W-1:0] A_ERR      = 8'h24;
  localparam logic [ADDR_W-1:0] A_TX_RAW   = 8'h80;
  localparam logic [ADDR_W-1:0] A_TX_MSK   = 8'h84;
  localparam logic [ADDR_W-1:0] A_TX_SET   = 8'h88;
  localparam logic [ADDR_W-1:0] A_TX_CLR   = 8'h8C;
  localparam logic [ADDR_W-1:0] A_EOI      = 8'h94;
  localparam logic [ADDR_W-1:0] A_RX_RAW   = 8'hA0;
  localparam logic [ADDR_W-1:0] A_RX_MSK   = 8'hA4;
  localparam logic [ADDR_W-1:0] A_RX_SET   = 8'hA8;
  localparam logic [ADDR_W-1:0] A_RX_CLR   = 8'hAC;
  localparam logic [ADDR_W-1:0] A_DMA_RAW  = 8'hB0;
  localparam logic [ADDR_W-1:0] A_DMA_MSK  = 8'hB4;
  localparam logic [ADDR_W-1:0] A_DMA_SET  = 8'hB8;
  localparam logic [ADDR_W-1:0] A_DMA_CLR  = 8'hBC;

  localparam int DMA_W = 2;
  localparam int HOST_ERR_BIT = 1;

  // Packed order of the stored error fields: tx code, tx chan, rx code, rx chan
  function automatic logic [ERR_W-1:0] err_from_word(input logic [DATA_W-1:0] w);
    return {w[23:20], w[18:16], w[15:12], w[10:8]};
  endfunction

  function automatic logic [DATA_W-1:0] err_to_word(input logic idle,
                                                     input logic [ERR_W-1:0] f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[31]    = idle;
    w[23:20] = f[13:10];
    w[18:16] = f[9:7];
    w[15:12] = f[6:3];
    w[10:8]  = f[2:0];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v);
    return v;
  endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         eoi_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] raw,
  output logic [W-1:0] mask
);
  logic [W-1:0] raw_nxt, mask_nxt;

  always_comb begin
    raw_nxt = (eoi_we ? '0 : raw) | evt;
    mask_nxt = mask;
    if (set_we)      mask_nxt = mask | wbits;
    else if (clr_we) mask_nxt = mask & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_nxt;
      mask <= mask_nxt;
    end
  end

  // R2 R8
  evt_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  // R3 R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(mask));

  // R7
  raw_clear_only_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_we |=> ((raw & $past(raw)) == $past(raw)));
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ERR_W-1:0]   hw_fields,
  input  logic               sw_we,
  input  logic [DATA_W-1:0]  sw_word,
  output logic [ERR_W-1:0]   fields
);
  always_ff @(posedge clk) begin
    if (!rst_n)        fields <= '0;
    else if (capture)  fields <= hw_fields;
    else if (sw_we)    fields <= err_from_word(sw_word);
  end

  // R11 R12
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (fields == $past(hw_fields)));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture || sw_we) |=> $stable(fields));
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    tx_done,
  input  logic [NCH-1:0]    rx_done,
  input  logic              host_err,
  input  logic              err_capture,
  input  logic [3:0]        err_tx_code,
  input  logic [2:0]        err_tx_chan,
  input  logic [3:0]        err_rx_code,
  input  logic [2:0]        err_rx_chan,
  input  logic              dma_idle,
  output logic              irq
);
  logic [NCH-1:0]   tx_raw, tx_mask, rx_raw, rx_mask;
  logic [DMA_W-1:0] dma_raw, dma_mask, dma_evt;
  logic [ERR_W-1:0] err_fields;
  logic [DATA_W-1:0] eoi_val;

  // Decoded write strobes, brought out for the assertions
  logic wr_eoi, wr_err;
  logic wr_tx_set, wr_tx_clr, wr_rx_set, wr_rx_clr, wr_dma_set, wr_dma_clr;

  assign wr_eoi     = reg_wr && (reg_addr == A_EOI);
  assign wr_err     = reg_wr && (reg_addr == A_ERR);
  assign wr_tx_set  = reg_wr && (reg_addr == A_TX_SET);
  assign wr_tx_clr  = reg_wr && (reg_addr == A_TX_CLR);
  assign wr_rx_set  = reg_wr && (reg_addr == A_RX_SET);
  assign wr_rx_clr  = reg_wr && (reg_addr == A_RX_CLR);
  assign wr_dma_set = reg_wr && (reg_addr == A_DMA_SET);
  assign wr_dma_clr = reg_wr && (reg_addr == A_DMA_CLR);

  always_comb begin
    dma_evt = '0;
    dma_evt[HOST_ERR_BIT] = host_err;
  end

  irq_group #(.W(NCH)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_done), .set_we(wr_tx_set),
    .clr_we(wr_tx_clr), .eoi_we(wr_eoi), .wbits(reg_wdata[NCH-1:0]),
    .raw(tx_raw), .mask(tx_mask));

  irq_group #(.W(NCH)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(rx_done), .set_we(wr_rx_set),
    .clr_we(wr_rx_clr), .eoi_we(wr_eoi), .wbits(reg_wdata[NCH-1:0]),
    .raw(rx_raw), .mask(rx_mask));

  irq_group #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .set_we(wr_dma_set),
    .clr_we(wr_dma_clr), .eoi_we(wr_eoi), .wbits(reg_wdata[DMA_W-1:0]),
    .raw(dma_raw), .mask(dma_mask));

  err_status_reg u_err (
    .clk(clk), .rst_n(rst_n), .capture(err_capture),
    .hw_fields({err_tx_code, err_tx_chan, err_rx_code, err_rx_chan}),
    .sw_we(wr_err), .sw_word(reg_wdata), .fields(err_fields));

  always_ff @(posedge clk) begin
    if (!rst_n)      eoi_val <= '0;
    else if (wr_eoi) eoi_val <= reg_wdata;
  end

  assign irq = |(tx_raw & tx_mask) | |(rx_raw & rx_mask) | |(dma_raw & dma_mask);

  always_comb begin
    unique case (reg_addr)
      A_ERR:     reg_rdata = err_to_word(dma_idle, err_fields);
      A_TX_RAW:  reg_rdata = widen(32'(tx_raw));
      A_TX_MSK:  reg_rdata = widen(32'(tx_raw & tx_mask));
      A_TX_SET,
      A_TX_CLR:  reg_rdata = widen(32'(tx_mask));
      A_EOI:     reg_rdata = eoi_val;
      A_RX_RAW:  reg_rdata = widen(32'(rx_raw));
      A_RX_MSK:  reg_rdata = widen(32'(rx_raw & rx_mask));
      A_RX_SET,
      A_RX_CLR:  reg_rdata = widen(32'(rx_mask));
      A_DMA_RAW: reg_rdata = widen(32'(dma_raw));
      A_DMA_MSK: reg_rdata = widen(32'(dma_raw & dma_mask));
      A_DMA_SET,
      A_DMA_CLR: reg_rdata = widen(32'(dma_mask));
      default:   reg_rdata = '0;
    endcase
  end

  // R6
  irq_low_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && !(|tx_done) && !(|rx_done) && !host_err) |=> !irq);

  // R7
  eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_eoi |=> $stable(eoi_val));
endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NCH-1:0] tx_done = 0, rx_done = 0;
  logic host_err = 0, err_capture = 0, dma_idle = 0, irq;
  logic [3:0] err_tx_code = 0, err_rx_code = 0;
  logic [2:0] err_tx_chan = 0, err_rx_chan = 0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_irq_unit #(.NCH(NCH)) uut (.*);

  // {tx, rx, host, tx_mask, rx_mask, dma_mask}
  localparam logic [34:0] VEC [0:5] = '{
    {8'h01, 8'h00, 1'b0, 8'h01, 8'h00, 2'b00},
    {8'h80, 8'h00, 1'b0, 8'h7F, 8'hFF, 2'b11},
    {8'h00, 8'hA5, 1'b0, 8'h00, 8'h0F, 2'b00},
    {8'h00, 8'h00, 1'b1, 8'hFF, 8'hFF, 2'b01},
    {8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 2'b10},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 8'hFF, 2'b11}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] r, input logic h);
    @(negedge clk); tx_done = t; rx_done = r; host_err = h;
    @(negedge clk); tx_done = 0; rx_done = 0; host_err = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h80, d); chk("R1 tx raw", d, 0);
    rd(8'hA8, d); chk("R1 rx mask", d, 0);
    rd(8'hB0, d); chk("R1 dma raw", d, 0);
    rd(8'h24, d); chk("R1 err", d, 0);
    rd(8'h94, d); chk("R1 eoi", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic [7:0] t, r, tm, rm; logic h; logic [1:0] dm;
      logic [1:0] dmasked; logic ei;
      {t, r, h, tm, rm, dm} = VEC[i];
      wr(8'h94, 32'h0);
      wr(8'h8C, 32'hFFFFFFFF); wr(8'hAC, 32'hFFFFFFFF); wr(8'hBC, 32'hFFFFFFFF);
      wr(8'h88, {24'b0, tm}); wr(8'hA8, {24'b0, rm}); wr(8'hB8, {30'b0, dm});
      pulse(t, r, h);
      dmasked = {h, 1'b0} & dm;
      ei = |(t & tm) | |(r & rm) | |dmasked;
      rd(8'h80, d); chk("R2 tx raw", d, {24'b0, t});
      rd(8'hA0, d); chk("R2 rx raw", d, {24'b0, r});
      rd(8'hB0, d); chk("R2 dma raw", d, {30'b0, h, 1'b0});
      rd(8'h84, d); chk("R5 tx masked", d, {24'b0, t & tm});
      rd(8'hA4, d); chk("R5 rx masked", d, {24'b0, r & rm});
      rd(8'hB4, d); chk("R5 dma masked", d, {30'b0, dmasked});
      chk("R6 irq", {31'b0, irq}, {31'b0, ei});
    end

    // R9 mask readback via set and clear offsets (masks now FF, FF, 3)
    rd(8'h8C, d); chk("R9 tx clr readback", d, 32'hFF);
    rd(8'hB8, d); chk("R9 dma set readback", d, 32'h3);
    // R4 all ones clear disables group although raw remains
    wr(8'h8C, 32'hFFFFFFFF);
    rd(8'h84, d); chk("R4 tx masked after clear", d, 0);
    rd(8'h80, d); chk("R4 tx raw kept", d, 32'hFF);
    // R3 zero bits leave mask unchanged
    wr(8'hA8, 32'h0);
    rd(8'hAC, d); chk("R3 rx mask unchanged", d, 32'hFF);
    wr(8'hA8 + 0, 32'h0);
    // R10 writes to status offsets ignored
    wr(8'h80, 32'h0); wr(8'h84, 32'hFFFFFFFF); wr(8'hA4, 32'h0);
    rd(8'h80, d); chk("R10 tx raw", d, 32'hFF);
    rd(8'h88, d); chk("R10 tx mask", d, 0);
    rd(8'hA0, d); chk("R10 rx raw", d, 32'hFF);
    // R7 eoi clears all, value read back
    wr(8'h94, 32'h0000_0A5C);
    rd(8'h94, d); chk("R7 eoi readback", d, 32'hA5C);
    rd(8'hA0, d); chk("R7 rx raw cleared", d, 0);
    rd(8'hB0, d); chk("R7 dma raw cleared", d, 0);
    chk("R7 irq low", {31'b0, irq}, 0);
    // R8 event on same edge as eoi
    @(negedge clk); reg_wr = 1; reg_addr = 8'h94; reg_wdata = 1; rx_done = 8'h10;
    @(negedge clk); reg_wr = 0; rx_done = 0;
    rd(8'hA0, d); chk("R8 event wins", d, 32'h10);
    chk("R8 irq", {31'b0, irq}, 1);

    // R11 error status
    dma_idle = 1;
    @(negedge clk); err_tx_code = 4'hC; err_tx_chan = 3'd5; err_rx_code = 4'h3;
    err_rx_chan = 3'd6; err_capture = 1;
    @(negedge clk); err_capture = 0;
    rd(8'h24, d); chk("R11 capture", d, 32'h80C5_3600);
    wr(8'h24, 32'h7FFF_FFFF);
    dma_idle = 0;
    rd(8'h24, d); chk("R11 sw write", d, 32'h00F7_F700);
    wr(8'h24, 32'h8000_0000);
    rd(8'h24, d); chk("R11 idle not writable", d, 32'h0);
    // R12 collision
    @(negedge clk); err_capture = 1; reg_wr = 1; reg_addr = 8'h24; reg_wdata = 32'h00F7_F700;
    err_tx_code = 4'h1; err_tx_chan = 3'd2; err_rx_code = 4'h4; err_rx_chan = 3'd1;
    @(negedge clk); err_capture = 0; reg_wr = 0;
    rd(8'h24, d); chk("R12 capture wins", d, 32'h0012_4100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule